// File: doc/BRIEF.md
# Coprocessor Dialogue Sequencer

This block sits on the main-processor side and conducts the command and response exchange with one of up to eight attached coprocessors. A one-cycle start pulse supplies a 3-bit coprocessor identifier and a 16-bit command word. The sequencer writes the command to the chosen device, then reads that device's response word and acts on what it finds. A busy answer makes it read again. A service answer makes it move one operand to or from the device. An exception answer makes it acknowledge the fault and hand a vector to the core. A release answer ends the exchange, so the core can continue while the coprocessor keeps working.

All traffic goes through ordinary single read and write bus cycles that this block masters. Each cycle is tagged with a reserved space code, and the address carries the identifier in its upper bits so that external select logic can pick the device. The coprocessor only answers; it never masters the bus. A bus error on any cycle stops the exchange and is reported as a protocol-violation exception.

Top module: `cpx_seq`

## Requirements
- R1: The bus address is {identifier[2:0], offset[4:0]}, so identifiers 0 to 7 each reach their own device. The offsets are: response word 0x00, command 0x0A, exception acknowledge 0x06, operand 0x10.
- R2: Every cycle drives bus_fc = 3'b111 while bus_cyc is high, and bus_fc is 0 otherwise. Address, direction and write data stay unchanged until bus_ack or bus_berr ends the cycle.
- R3: After a start pulse, the first bus cycle writes cmd_word to the command offset 0x0A of the selected device.
- R4: After the command write, the block reads the response word at offset 0x00. Its fields are: bit 15 re-query flag, bits 14:13 type (00 release, 01 busy, 10 service, 11 exception), bit 12 direction (1 = to coprocessor), bits 7:0 exception vector.
- R5: A busy response is followed by another read of offset 0x00. This repeats until some other type is returned.
- R6: An exception response is followed by a write of {8'h00, vector} to offset 0x06. After that write, exc pulses for one cycle with exc_vec holding the vector.
- R7: A service response runs one cycle at offset 0x10. With direction 1 it writes opnd_wdata. With direction 0 it reads the device, and the value read appears on opnd_rdata with a one-cycle opnd_rvalid pulse.
- R8: After a service transfer, a set re-query flag leads to another response read. A clear flag ends the exchange with done.
- R9: A release response ends the exchange: done pulses for one cycle, busy falls, and no further bus cycle starts.
- R10: A bus error on any cycle aborts the exchange. No further cycle is started, and exc pulses with exc_vec = PROTO_VEC (default 8'h0E).
- R11: busy is high from the cycle after an accepted start until the exchange ends. A start pulse while busy is ignored.
- R12: After reset, done, exc, opnd_rvalid, busy, bus_cyc and bus_fc are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an exchange (ignored while busy) |
| cp_id | input | 3 | Coprocessor identifier |
| cmd_word | input | 16 | Command word to write |
| opnd_wdata | input | 16 | Operand sent on a transfer toward the coprocessor |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle pulse: exchange finished normally |
| exc | output | 1 | One-cycle pulse: exception reported |
| exc_vec | output | 8 | Exception vector, valid with exc |
| opnd_rdata | output | 16 | Operand read from the coprocessor |
| opnd_rvalid | output | 1 | One-cycle pulse: opnd_rdata is new |
| bus_cyc | output | 1 | Bus cycle request, held until ack or error |
| bus_addr | output | 8 | {identifier, register offset} |
| bus_fc | output | 3 | Space code, 3'b111 during coprocessor cycles |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, sampled with bus_ack |
| bus_ack | input | 1 | Cycle completed |
| bus_berr | input | 1 | Cycle failed with a bus error |

## Verification
The assertions assume that bus_ack and bus_berr are raised only while bus_cyc is high, never both together, and at most once per cycle. They also assume that bus_rdata is valid in the same clock as bus_ack. The bench's scripted coprocessor raises ack or berr only after it has seen a new request. It adds zero to two wait states and drops its reply right after the completing edge, so the stimulus keeps within those assumptions. The response scripts always end in a release, a service without re-query, an exception or an injected bus error, so every exchange terminates.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_POLL,
    ST_XFER,
    ST_EACK
  } cpx_state_e;

  typedef enum logic [1:0] {
    RT_RELEASE = 2'b00,
    RT_BUSY    = 2'b01,
    RT_SERVICE = 2'b10,
    RT_EXCEPT  = 2'b11
  } cpx_rtype_e;

  localparam int OFW = 5;
  localparam logic [OFW-1:0] OFF_RESP = 5'h00;
  localparam logic [OFW-1:0] OFF_EACK = 5'h06;
  localparam logic [OFW-1:0] OFF_CMD  = 5'h0A;
  localparam logic [OFW-1:0] OFF_OPND = 5'h10;
endpackage

// File: rtl/cpx_resp_decode.sv
module cpx_resp_decode
  import cpx_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] resp,
  output logic          requery,
  output cpx_rtype_e    rtype,
  output logic          to_cp,
  output logic [7:0]    vec
);
  always_comb begin
    requery = resp[15];
    rtype   = cpx_rtype_e'(resp[14:13]);
    to_cp   = resp[12];
    vec     = resp[7:0];
  end
endmodule

// File: rtl/cpx_addr_gen.sv
module cpx_addr_gen #(
  parameter int IDW = 3,
  parameter int OFW = 5,
  localparam int AW = IDW + OFW
) (
  input  logic [IDW-1:0] id,
  input  logic [OFW-1:0] off,
  output logic [AW-1:0]  addr
);
  assign addr = {id, off};
endmodule

// File: rtl/cpx_seq.sv
module cpx_seq
  import cpx_pkg::*;
#(
  parameter int         DW        = 16,
  parameter int         IDW       = 3,
  parameter logic [2:0] CP_FC     = 3'b111,
  parameter logic [7:0] PROTO_VEC = 8'h0E,
  localparam int        AW        = IDW + cpx_pkg::OFW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [IDW-1:0] cp_id,
  input  logic [DW-1:0]  cmd_word,
  input  logic [DW-1:0]  opnd_wdata,
  output logic           busy,
  output logic           done,
  output logic           exc,
  output logic [7:0]     exc_vec,
  output logic [DW-1:0]  opnd_rdata,
  output logic           opnd_rvalid,
  output logic           bus_cyc,
  output logic [AW-1:0]  bus_addr,
  output logic [2:0]     bus_fc,
  output logic           bus_we,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata,
  input  logic           bus_ack,
  input  logic           bus_berr
);
  cpx_state_e     state;
  logic [IDW-1:0] id_q;
  logic [DW-1:0]  cmd_q;
  logic           to_cp_q;
  logic           requery_q;
  logic [7:0]     vec_q;

  logic [OFW-1:0] off_nxt;
  logic           we_nxt;
  logic [DW-1:0]  wd_nxt;
  logic [AW-1:0]  addr_nxt;

  logic           r_requery;
  cpx_rtype_e     r_type;
  logic           r_to_cp;
  logic [7:0]     r_vec;

  cpx_resp_decode #(.DW(DW)) u_dec (
    .resp    (bus_rdata),
    .requery (r_requery),
    .rtype   (r_type),
    .to_cp   (r_to_cp),
    .vec     (r_vec)
  );

  cpx_addr_gen #(.IDW(IDW), .OFW(OFW)) u_addr (
    .id   (id_q),
    .off  (off_nxt),
    .addr (addr_nxt)
  );

  // Launch values for the access belonging to the current state
  always_comb begin
    off_nxt = OFF_RESP;
    we_nxt  = 1'b0;
    wd_nxt  = '0;
    unique case (state)
      ST_CMD: begin
        off_nxt = OFF_CMD;
        we_nxt  = 1'b1;
        wd_nxt  = cmd_q;
      end
      ST_XFER: begin
        off_nxt = OFF_OPND;
        we_nxt  = to_cp_q;
        wd_nxt  = opnd_wdata;
      end
      ST_EACK: begin
        off_nxt = OFF_EACK;
        we_nxt  = 1'b1;
        wd_nxt  = {{(DW-8){1'b0}}, vec_q};
      end
      default: ;
    endcase
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      id_q        <= '0;
      cmd_q       <= '0;
      to_cp_q     <= 1'b0;
      requery_q   <= 1'b0;
      vec_q       <= '0;
      done        <= 1'b0;
      exc         <= 1'b0;
      exc_vec     <= '0;
      opnd_rdata  <= '0;
      opnd_rvalid <= 1'b0;
      bus_cyc     <= 1'b0;
      bus_addr    <= '0;
      bus_fc      <= '0;
      bus_we      <= 1'b0;
      bus_wdata   <= '0;
    end else begin
      done        <= 1'b0;
      exc         <= 1'b0;
      opnd_rvalid <= 1'b0;
      if (state == ST_IDLE) begin
        if (start) begin
          id_q  <= cp_id;
          cmd_q <= cmd_word;
          state <= ST_CMD;
        end
      end else if (!bus_cyc) begin
        bus_cyc   <= 1'b1;
        bus_fc    <= CP_FC;
        bus_addr  <= addr_nxt;
        bus_we    <= we_nxt;
        bus_wdata <= wd_nxt;
      end else if (bus_berr) begin
        bus_cyc <= 1'b0;
        bus_fc  <= '0;
        exc     <= 1'b1;
        exc_vec <= PROTO_VEC;
        state   <= ST_IDLE;
      end else if (bus_ack) begin
        bus_cyc <= 1'b0;
        bus_fc  <= '0;
        unique case (state)
          ST_CMD: state <= ST_POLL;
          ST_POLL: begin
            unique case (r_type)
              RT_BUSY:    state <= ST_POLL;
              RT_RELEASE: begin
                done  <= 1'b1;
                state <= ST_IDLE;
              end
              RT_SERVICE: begin
                to_cp_q   <= r_to_cp;
                requery_q <= r_requery;
                state     <= ST_XFER;
              end
              default: begin
                vec_q <= r_vec;
                state <= ST_EACK;
              end
            endcase
          end
          ST_XFER: begin
            if (!to_cp_q) begin
              opnd_rdata  <= bus_rdata;
              opnd_rvalid <= 1'b1;
            end
            if (requery_q) state <= ST_POLL;
            else begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end
          end
          default: begin
            exc     <= 1'b1;
            exc_vec <= vec_q;
            state   <= ST_IDLE;
          end
        endcase
      end
    end
  end

  // Space code present during every coprocessor cycle
  assert_fc_R2: assert property (@(posedge clk) disable iff (rst)
    bus_cyc |-> bus_fc == CP_FC);

  // Request fields held until the slave answers
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && !bus_ack && !bus_berr) |=>
      (bus_cyc && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  // Identifier occupies the upper address bits
  assert_id_R1: assert property (@(posedge clk) disable iff (rst)
    bus_cyc |-> bus_addr[AW-1:OFW] == id_q);

  // Bus error aborts with the protocol-violation vector
  assert_berr_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_berr) |=> (exc && exc_vec == PROTO_VEC && !bus_cyc && !busy));

  // Normal completion leaves the bus quiet
  assert_release_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!bus_cyc && !busy && !exc));

  // Exception reporting returns to idle
  assert_exc_R6: assert property (@(posedge clk) disable iff (rst)
    exc |-> (!busy && !done));
endmodule

// File: tb/sim_cpx_seq.sv
module sim_cpx_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  cp_id = '0;
  logic [15:0] cmd_word = '0;
  logic [15:0] opnd_wdata = '0;
  logic        busy, done, exc, opnd_rvalid;
  logic [7:0]  exc_vec;
  logic [15:0] opnd_rdata;
  logic        bus_cyc, bus_we;
  logic [7:0]  bus_addr;
  logic [2:0]  bus_fc;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_ack = 1'b0;
  logic        bus_berr = 1'b0;

  localparam logic [7:0] PROTO = 8'h0E;

  always #5 clk = ~clk;

  cpx_seq u0 (
    .clk(clk), .rst(rst), .start(start), .cp_id(cp_id), .cmd_word(cmd_word),
    .opnd_wdata(opnd_wdata), .busy(busy), .done(done), .exc(exc),
    .exc_vec(exc_vec), .opnd_rdata(opnd_rdata), .opnd_rvalid(opnd_rvalid),
    .bus_cyc(bus_cyc), .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .bus_berr(bus_berr)
  );

  int checks = 0;
  int errors = 0;

  // Reference transaction list built by the model
  logic [7:0]  ea[$];
  logic        ew[$];
  logic [15:0] ed[$];
  logic [15:0] er[$];
  logic        eb[$];
  logic [15:0] script[$];

  int          n_done, n_exc, n_rv, txn_no;
  logic [7:0]  got_vec;
  logic [15:0] got_rd;
  logic        in_txn = 1'b0;
  int          wait_cnt;
  logic [7:0]  cur_addr;
  logic        cur_b;
  logic [15:0] cur_r;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Scripted coprocessor and per-clock comparison
  always @(negedge clk) begin
    bus_ack  = 1'b0;
    bus_berr = 1'b0;
    if (!rst) begin
      if (done) n_done++;
      if (exc) begin n_exc++; got_vec = exc_vec; end
      if (opnd_rvalid) begin n_rv++; got_rd = opnd_rdata; end
      if (!busy) chk(!bus_cyc, "R11 bus idle when not busy", bus_cyc, 0);
      if (bus_cyc && !in_txn) begin
        in_txn = 1'b1;
        wait_cnt = txn_no % 3;
        txn_no++;
        chk(bus_fc == 3'b111, "R2 space code", bus_fc, 3'b111);
        if (ea.size() == 0) begin
          chk(0, "R9 unexpected bus cycle", bus_addr, 0);
          cur_addr = bus_addr; cur_b = 1'b0; cur_r = '0;
        end else begin
          chk(bus_addr == ea[0], "R1/R3/R4 address", bus_addr, ea[0]);
          chk(bus_we == ew[0], "R7 direction", bus_we, ew[0]);
          if (ew[0]) chk(bus_wdata == ed[0], "R6/R7 write data", bus_wdata, ed[0]);
          cur_addr = bus_addr; cur_b = eb[0]; cur_r = er[0];
          void'(ea.pop_front()); void'(ew.pop_front()); void'(ed.pop_front());
          void'(er.pop_front()); void'(eb.pop_front());
        end
      end
      if (in_txn) begin
        if (wait_cnt == 0) begin
          chk(bus_cyc && bus_addr == cur_addr, "R2 request held", bus_addr, cur_addr);
          bus_rdata = cur_r;
          if (cur_b) bus_berr = 1'b1; else bus_ack = 1'b1;
          in_txn = 1'b0;
        end else wait_cnt--;
      end
    end
  end

  task automatic run_op(input string tag, input logic [2:0] id, input logic [15:0] cmd,
                        input logic [15:0] wdat, input logic [15:0] opval,
                        input int berr_at, input bit restart);
    bit ev_done = 0, ev_exc = 0, ev_rd = 0, fin = 0;
    logic [7:0] ev_vec = '0;
    int idx = 0, rd_pos = -1;
    logic [15:0] r;
    ea.delete(); ew.delete(); ed.delete(); er.delete(); eb.delete();
    ea.push_back({id, 5'h0A}); ew.push_back(1); ed.push_back(cmd); er.push_back(0); eb.push_back(0);
    while (!fin && idx < script.size()) begin
      r = script[idx]; idx++;
      ea.push_back({id, 5'h00}); ew.push_back(0); ed.push_back(0); er.push_back(r); eb.push_back(0);
      case (r[14:13])
        2'b01: ;
        2'b00: begin ev_done = 1; fin = 1; end
        2'b11: begin
          ea.push_back({id, 5'h06}); ew.push_back(1); ed.push_back({8'h00, r[7:0]});
          er.push_back(0); eb.push_back(0);
          ev_exc = 1; ev_vec = r[7:0]; fin = 1;
        end
        default: begin
          if (r[12]) begin
            ea.push_back({id, 5'h10}); ew.push_back(1); ed.push_back(wdat); er.push_back(0);
          end else begin
            rd_pos = ea.size();
            ea.push_back({id, 5'h10}); ew.push_back(0); ed.push_back(0); er.push_back(opval);
            ev_rd = 1;
          end
          eb.push_back(0);
          if (!r[15]) begin ev_done = 1; fin = 1; end
        end
      endcase
    end
    if (berr_at >= 0) begin
      while (ea.size() > berr_at + 1) begin
        void'(ea.pop_back()); void'(ew.pop_back()); void'(ed.pop_back());
        void'(er.pop_back()); void'(eb.pop_back());
      end
      eb[berr_at] = 1'b1;
      ev_done = 0; ev_exc = 1; ev_vec = PROTO;
      if (rd_pos >= berr_at) ev_rd = 0;
    end
    n_done = 0; n_exc = 0; n_rv = 0;
    @(negedge clk);
    start = 1; cp_id = id; cmd_word = cmd; opnd_wdata = wdat;
    @(negedge clk);
    start = 0;
    chk(busy, {tag, " R11 busy after start"}, busy, 1);
    if (restart) begin
      @(negedge clk);
      start = 1; cp_id = id + 3'd1; cmd_word = ~cmd;
      @(negedge clk);
      start = 0;
    end
    for (int i = 0; i < 400 && (n_done + n_exc) == 0; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(n_done == int'(ev_done), {tag, " R8/R9 done count"}, n_done, ev_done);
    chk(n_exc == int'(ev_exc), {tag, " R6/R10 exc count"}, n_exc, ev_exc);
    if (ev_exc) chk(got_vec == ev_vec, {tag, " R6/R10 vector"}, got_vec, ev_vec);
    chk(n_rv == int'(ev_rd), {tag, " R7 read valid count"}, n_rv, ev_rd);
    if (ev_rd) chk(got_rd == opval, {tag, " R7 read data"}, got_rd, opval);
    chk(ea.size() == 0, {tag, " R4/R5 all cycles seen"}, ea.size(), 0);
    chk(!busy, {tag, " R9 busy low at end"}, busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk(!done && !exc && !opnd_rvalid, "R12 pulses low", {done, exc, opnd_rvalid}, 0);
    chk(!busy && !bus_cyc && bus_fc == 0, "R12 bus idle", {busy, bus_cyc, bus_fc}, 0);

    script = '{16'h0000};
    run_op("release R3", 3'd3, 16'h1234, 16'h0, 16'h0, -1, 0);
    script = '{16'h2000, 16'h2000, 16'h0000};
    run_op("busy R5", 3'd5, 16'hABCD, 16'h0, 16'h0, -1, 0);
    script = '{16'h6042};
    run_op("exception R6", 3'd0, 16'h0F0F, 16'h0, 16'h0, -1, 0);
    script = '{16'h5000};
    run_op("svc write R7", 3'd7, 16'h5555, 16'hBEEF, 16'h0, -1, 0);
    script = '{16'hC000, 16'h2000, 16'h0000};
    run_op("svc read requery R8", 3'd2, 16'h7777, 16'h0, 16'hCAFE, -1, 0);
    script = '{16'h0000};
    run_op("berr on poll R10", 3'd1, 16'h1111, 16'h0, 16'h0, 1, 0);
    script = '{16'h0000};
    run_op("berr on cmd R10", 3'd6, 16'h2222, 16'h0, 16'h0, 0, 0);
    script = '{16'h2000, 16'h2000, 16'h2000, 16'h0000};
    run_op("restart ignored R11", 3'd4, 16'h3333, 16'h0, 16'h0, -1, 1);
    for (int k = 0; k < 8; k++) begin
      script = '{16'h0000};
      run_op("all ids R1", 3'(k), 16'(k * 16'h0101), 16'h0, 16'h0, -1, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule